// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block takes packets arriving as a byte stream with start and end markers and scatters them into buffers in host memory. Host software describes those buffers with a ring of two-word descriptors. For each packet the engine reads the descriptor at the current pointer and checks that hardware owns it. It then fetches the buffer address and fills the buffer with as many bytes as it can take. When more bytes remain, it looks at the next descriptor's control word to decide whether the packet may spill over into that descriptor.

The engine writes a status word back into every descriptor it uses, with one exception: the status of the first descriptor of a packet is held back until the whole chain has been written. Software therefore never sees a half-built chain. An interrupt pulse follows that final write. Two registers hold the ring start address and the current descriptor pointer. All memory traffic goes through one 32-bit master port with a request/ready handshake.

Top module: `rxring_dma_writer`

## Requirements
- R1: A descriptor is two 32-bit words eight bytes apart: the control/status word at the descriptor address and the buffer address at descriptor address + 4. Buffer bytes are written little-end-first into words starting at the buffer address, with its low two bits ignored. Byte k of a word carries byte-enable bit k, and a trailing partial word enables only the bytes it holds.
- R2: If the ring start register is zero when a packet starts, the whole packet is consumed with no memory write, no interrupt and no pointer change.
- R3: If bit 31 (ownership) of the current descriptor's control word is clear, the packet is consumed with no memory write, no interrupt and no pointer change.
- R4: Each descriptor receives the smaller of its buffer length (control bits 12:0) and the bytes still to store. A buffer that fills on the packet's last byte completes the packet.
- R5: The descriptor after the current one is the ring start if control bit 30 (wrap) is set, otherwise the current address + 8. After a packet, the current pointer names the descriptor after the last one used.
- R6: When bytes remain and the next descriptor is owned, the current status becomes bit 27 (continue) ORed with the bytes copied.
- R7: When bytes remain and the next descriptor is not owned, the current status becomes the bytes copied with no flag, and the rest of the packet is discarded.
- R8: The descriptor that completes a packet gets the status copied bytes + 4, with all flag bits clear.
- R9: The first descriptor's status is written exactly once, as the last write of the packet. The interrupt is a one-cycle pulse in the cycle after that write.
- R10: At most MAX_PKT bytes of a packet are stored. The byte that reaches the limit completes the packet, and the bytes after it are discarded.
- R11: Register offset 0x4 is the ring start and offset 0x8 the current pointer, both read/write with the low three bits forced to zero. Other offsets read zero and ignore writes. A software write to the pointer takes priority over an engine advance in the same cycle.
- R12: A memory request holds its direction and write data until ready, and every request address is word aligned.
- R13: A descriptor with buffer length zero stores nothing and is chained or closed per R6/R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| pkt_valid | input | 1 | Packet byte valid |
| pkt_sop | input | 1 | Byte is the first of a packet |
| pkt_eop | input | 1 | Byte is the last of a packet |
| pkt_data | input | 8 | Packet byte |
| pkt_ready | output | 1 | Byte accepted when high with pkt_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| irq | output | 1 | One-cycle packet-stored pulse |

## Verification
The buffer filling up and the packet ending can happen on the same accepted byte. The truncation limit can also land on a byte that fills a buffer. In either case the completion path must win over chaining, so the status carries length + 4 with no continue flag and the pointer advances by exactly one descriptor. The sweep provokes this by crossing buffer lengths 1, 3, 4, 5 and 12 with packet lengths 1, 4, 5, 9, 13 and 45, which includes exact multiples and a length beyond the limit. Each result is compared with a descriptor-by-descriptor arithmetic model of status words, buffer bytes, guard bytes and the final pointer.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int OWN_BIT    = 31;
   localparam int WRAP_BIT   = 30;
   localparam int CONT_BIT   = 27;
   localparam int DESC_BYTES = 8;
   localparam int LANES      = 4;
   localparam int LANE_W     = 2;
   localparam int RING_OFS   = 4;
   localparam int CUR_OFS    = 8;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RD_CTRL, ST_RD_BUF, ST_FILL, ST_WR_DATA,
      ST_RD_NEXT, ST_WR_STAT, ST_WR_FIRST, ST_DRAIN
   } rxr_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              adv_en,
   input  logic [ADDR_W-1:0] adv_ptr,
   output logic [ADDR_W-1:0] ring_start,
   output logic [ADDR_W-1:0] cur_ptr
);
   logic              hit_ring, hit_cur;
   logic [ADDR_W-1:0] wr_aligned;
   logic              unused_low;

   assign hit_ring   = (reg_addr == REG_AW'(RING_OFS));
   assign hit_cur    = (reg_addr == REG_AW'(CUR_OFS));
   assign wr_aligned = {reg_wdata[ADDR_W-1:3], 3'b000};
   assign unused_low = ^reg_wdata[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_start <= '0;
         cur_ptr    <= '0;
      end else begin
         if (reg_wr && hit_ring) ring_start <= wr_aligned;
         if (reg_wr && hit_cur)  cur_ptr    <= wr_aligned;
         else if (adv_en)        cur_ptr    <= adv_ptr;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_ring)     reg_rdata = ring_start;
      else if (hit_cur) reg_rdata = cur_ptr;
   end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
   import rxr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [7:0]        din,
   output logic [LANE_W-1:0] lane_o,
   output logic [31:0]       word_o,
   output logic [LANES-1:0]  be_o
);
   logic [LANE_W-1:0] lane_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q <= '0;
      else if (clr)  lane_q <= '0;
      else if (push) lane_q <= lane_q + 1'b1;
   end
   assign lane_o = lane_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] b_q;
      logic       v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_q <= '0;
            v_q <= 1'b0;
         end else if (clr) begin
            b_q <= '0;
            v_q <= 1'b0;
         end else if (push && lane_q == LANE_W'(g)) begin
            b_q <= din;
            v_q <= 1'b1;
         end
      end
      assign word_o[g*8 +: 8] = b_q;
      assign be_o[g]          = v_q;
   end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 13,
   parameter int MAX_PKT = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_start,
   input  logic [ADDR_W-1:0] cur_ptr,
   output logic              adv_en,
   output logic [ADDR_W-1:0] adv_ptr,
   input  logic              pkt_valid,
   input  logic              pkt_sop,
   input  logic              pkt_eop,
   output logic              pkt_ready,
   output logic              pk_push,
   output logic              pk_clr,
   input  logic [LANE_W-1:0] pk_lane,
   input  logic [31:0]       pk_word,
   input  logic [LANES-1:0]  pk_be,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_be,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              irq
);
   localparam int          TOT_W     = $clog2(MAX_PKT + 1);
   localparam logic [31:0] CONT_FLAG = 32'd1 << CONT_BIT;

   rxr_state_e        state_q;
   logic              wrap_q, nwrap_q;
   logic [LEN_W-1:0]  len_q, nlen_q, copied_q, cp_inc, last_idx;
   logic [TOT_W-1:0]  total_q, tot_inc;
   logic [ADDR_W-1:0] buf_q, first_addr_q, next_addr, data_addr;
   logic [31:0]       stat_q, first_stat_q;
   logic              first_q, done_q, eop_q, stop_q, dend_q, irq_q;
   logic              accept, go, fin_byte, full_byte, stat_done;
   logic              unused_buf;

   assign accept    = pkt_valid && pkt_ready;
   assign go        = mem_req && mem_ready;
   assign cp_inc    = copied_q + 1'b1;
   assign tot_inc   = total_q + 1'b1;
   assign fin_byte  = pkt_eop || (tot_inc == TOT_W'(MAX_PKT));
   assign full_byte = (cp_inc == len_q);
   assign last_idx  = copied_q - 1'b1;
   assign next_addr = wrap_q ? ring_start : cur_ptr + ADDR_W'(DESC_BYTES);
   assign data_addr = {buf_q[ADDR_W-1:2], 2'b00}
                    + ADDR_W'({last_idx[LEN_W-1:2], 2'b00});
   assign stat_done = (state_q == ST_WR_STAT) && (first_q || mem_ready);
   assign unused_buf = ^buf_q[1:0];
   assign irq       = irq_q;

   always_comb begin
      mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
      mem_be = 4'hF; pkt_ready = 1'b0; pk_push = 1'b0;
      pk_clr = 1'b0; adv_en = 1'b0; adv_ptr = next_addr;
      case (state_q)
         ST_IDLE:     pkt_ready = !pkt_sop;
         ST_RD_CTRL:  begin mem_req = 1'b1; mem_addr = cur_ptr; end
         ST_RD_BUF:   begin
            mem_req = 1'b1; mem_addr = cur_ptr + ADDR_W'(4); pk_clr = 1'b1;
         end
         ST_FILL:     begin pkt_ready = 1'b1; pk_push = accept; end
         ST_WR_DATA:  begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = data_addr;
            mem_wdata = pk_word; mem_be = pk_be; pk_clr = mem_ready;
         end
         ST_RD_NEXT:  begin mem_req = 1'b1; mem_addr = next_addr; end
         ST_WR_STAT:  begin
            mem_req = !first_q; mem_we = 1'b1; mem_addr = cur_ptr;
            mem_wdata = stat_q; adv_en = stat_done;
         end
         ST_WR_FIRST: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = first_addr_q;
            mem_wdata = first_stat_q;
         end
         ST_DRAIN:    pkt_ready = 1'b1;
         default:     ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE; wrap_q <= 1'b0; nwrap_q <= 1'b0;
         len_q <= '0; nlen_q <= '0; copied_q <= '0; total_q <= '0;
         buf_q <= '0; first_addr_q <= '0; stat_q <= '0; first_stat_q <= '0;
         first_q <= 1'b0; done_q <= 1'b0; eop_q <= 1'b0; stop_q <= 1'b0;
         dend_q <= 1'b0; irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (pkt_valid && pkt_sop) begin
               first_q <= 1'b1; first_addr_q <= cur_ptr; total_q <= '0;
               copied_q <= '0; done_q <= 1'b0; eop_q <= 1'b0; stop_q <= 1'b0;
               state_q <= (ring_start == '0) ? ST_DRAIN : ST_RD_CTRL;
            end
            ST_RD_CTRL: if (go) begin
               wrap_q  <= mem_rdata[WRAP_BIT];
               len_q   <= mem_rdata[LEN_W-1:0];
               state_q <= mem_rdata[OWN_BIT] ? ST_RD_BUF : ST_DRAIN;
            end
            ST_RD_BUF: if (go) begin
               buf_q    <= mem_rdata[ADDR_W-1:0];
               copied_q <= '0;
               state_q  <= (len_q == '0) ? ST_RD_NEXT : ST_FILL;
            end
            ST_FILL: if (accept) begin
               copied_q <= cp_inc; total_q <= tot_inc; eop_q <= pkt_eop;
               done_q <= fin_byte; dend_q <= fin_byte || full_byte;
               if (pk_lane == LANE_W'(LANES - 1) || fin_byte || full_byte)
                  state_q <= ST_WR_DATA;
            end
            ST_WR_DATA: if (go) begin
               if (!dend_q) state_q <= ST_FILL;
               else if (done_q) begin
                  stat_q  <= 32'(copied_q) + 32'd4;
                  state_q <= ST_WR_STAT;
               end else state_q <= ST_RD_NEXT;
            end
            ST_RD_NEXT: if (go) begin
               nwrap_q <= mem_rdata[WRAP_BIT];
               nlen_q  <= mem_rdata[LEN_W-1:0];
               if (mem_rdata[OWN_BIT]) stat_q <= CONT_FLAG | 32'(copied_q);
               else begin
                  stat_q <= 32'(copied_q);
                  stop_q <= 1'b1;
               end
               state_q <= ST_WR_STAT;
            end
            ST_WR_STAT: if (stat_done) begin
               first_q <= 1'b0;
               if (first_q) first_stat_q <= stat_q;
               if (done_q || stop_q) state_q <= ST_WR_FIRST;
               else begin
                  wrap_q <= nwrap_q; len_q <= nlen_q; state_q <= ST_RD_BUF;
               end
            end
            ST_WR_FIRST: if (go) begin
               irq_q   <= 1'b1;
               state_q <= eop_q ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: if (accept && pkt_eop) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: completion interrupt lasts exactly one cycle
   assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R12: a stalled request keeps its direction and data
   assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_wdata));
   // R12: word-aligned addresses only
   assert_word_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);
   // R4: never copy past the buffer length
   assert_copy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FILL |-> copied_q < len_q);
   // R10: stored byte count stays under the limit while filling
   assert_trunc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FILL |-> total_q < TOT_W'(MAX_PKT));
endmodule

// File: rtl/rxring_dma_writer.sv
module rxring_dma_writer
   import rxr_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int REG_AW  = 4,
   parameter int LEN_W   = 13,
   parameter int MAX_PKT = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              pkt_valid,
   input  logic              pkt_sop,
   input  logic              pkt_eop,
   input  logic [7:0]        pkt_data,
   output logic              pkt_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_be,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              irq
);
   if (LEN_W < 2 || LEN_W > CONT_BIT) begin : g_bad_len
      initial $error("LEN_W must lie between 2 and the continue flag position");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      initial $error("ADDR_W must lie between 8 and 32");
   end
   if (MAX_PKT < 1) begin : g_bad_max
      initial $error("MAX_PKT must be positive");
   end

   logic [ADDR_W-1:0] ring_start, cur_ptr, adv_ptr;
   logic              adv_en, pk_push, pk_clr;
   logic [LANE_W-1:0] pk_lane;
   logic [31:0]       pk_word;
   logic [LANES-1:0]  pk_be;

   rxr_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
      .adv_en, .adv_ptr, .ring_start, .cur_ptr);

   rxr_packer u_pack (
      .clk, .rst_n, .clr(pk_clr), .push(pk_push), .din(pkt_data),
      .lane_o(pk_lane), .word_o(pk_word), .be_o(pk_be));

   rxr_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) u_eng (
      .clk, .rst_n, .ring_start, .cur_ptr, .adv_en, .adv_ptr,
      .pkt_valid, .pkt_sop, .pkt_eop, .pkt_ready,
      .pk_push, .pk_clr, .pk_lane, .pk_word, .pk_be,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_be, .mem_ready,
      .mem_rdata, .irq);
endmodule

// File: tb/tb_rxring_dma_writer.sv
module tb_rxring_dma_writer;
   localparam int CLK_PERIOD = 10;
   localparam int MAXP  = 40;
   localparam int NDESC = 6;
   localparam logic [31:0] RING = 32'h40, BUFB = 32'h100, BSTR = 32'h20;
   localparam logic [31:0] OWN = 32'h8000_0000, WRAP = 32'h4000_0000, CONT = 32'h0800_0000;

   logic clk = 0, rst_n = 0;
   logic [3:0] reg_addr = 0; logic reg_wr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
   logic pkt_valid = 0, pkt_sop = 0, pkt_eop = 0, pkt_ready; logic [7:0] pkt_data = 0;
   logic mem_req, mem_we, mem_ready, irq; logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0] mem_be;
   logic [31:0] mem [0:127];
   logic [1:0] gcnt = 0;
   int checks = 0, errors = 0, wr_cnt = 0, irq_cnt = 0, wide_cnt = 0, mis_cnt = 0, first_wr_cnt = 0;
   logic [31:0] last_wr = 0, irq_last_wr = 0, first_watch = 0;
   logic irq_prev = 0; bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxring_dma_writer #(.MAX_PKT(MAXP)) dut (.*);

   assign mem_ready = mem_req && (gcnt != 2'd2);
   assign mem_rdata = mem[mem_addr[8:2]];

   always @(posedge clk) begin
      gcnt <= gcnt + 1'b1;
      if (rst_n) begin
         if (irq) begin irq_cnt++; irq_last_wr = last_wr; end
         if (irq && irq_prev) wide_cnt++;
         irq_prev = irq;
         if (mem_req && mem_addr[1:0] != 2'b00) mis_cnt++;
         if (mem_req && mem_ready && mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[8:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            wr_cnt++; last_wr = mem_addr;
            if (mem_addr == first_watch) first_wr_cnt++;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   function automatic logic [7:0] pb(input int seed, input int k);
      return 8'((seed * 13 + k * 7) & 255);
   endfunction

   function automatic logic [7:0] byte_at(input logic [31:0] a);
      return mem[a[8:2]][8*a[1:0] +: 8];
   endfunction

   task automatic send_pkt(input int p, input int seed);
      @(negedge clk);
      for (int k = 0; k < p; k++) begin
         pkt_valid = 1; pkt_data = pb(seed, k); pkt_sop = (k == 0); pkt_eop = (k == p - 1);
         #1;
         while (!pkt_ready) begin @(negedge clk); #1; end
         @(negedge clk);
      end
      pkt_valid = 0; pkt_sop = 0; pkt_eop = 0;
   endtask

   function automatic int dlen(input int d, input int start, input int len, input bit zl);
      return (zl && ((d - start + NDESC) % NDESC) == 1) ? 0 : len;
   endfunction

   task automatic setup_ring(input int start, input int k, input int len, input bit zl);
      for (int i = 0; i < 128; i++) mem[i] = 32'hEEEE_EEEE;
      for (int d = 0; d < NDESC; d++) begin
         mem[(RING >> 2) + 2*d] = ((((d - start + NDESC) % NDESC) < k) ? OWN : 32'h0)
                                | ((d == NDESC - 1) ? WRAP : 32'h0) | 32'(dlen(d, start, len, zl));
         mem[(RING >> 2) + 2*d + 1] = BUFB + BSTR * d;
      end
   endtask

   task automatic run_case(input int len, input int p, input int start, input int k,
                           input bit zl, input int seed);
      int rem, off, used, cp, bad, d, untouched;
      logic [31:0] exp, rd, ba;
      string tag;
      setup_ring(start, k, len, zl);
      reg_write(4'h4, RING);
      reg_write(4'h8, RING + 8 * start);
      wr_cnt = 0; irq_cnt = 0; first_wr_cnt = 0; first_watch = RING + 8 * start;
      send_pkt(p, seed);
      repeat (80) @(negedge clk);
      if (k == 0) begin
         check(wr_cnt == 0, "R3 no write when not owned", wr_cnt, 0);
         check(irq_cnt == 0, "R3 no interrupt when not owned", irq_cnt, 0);
         reg_read(4'h8, rd);
         check(rd == RING + 8 * start, "R3 pointer kept", rd, RING + 8 * start);
         return;
      end
      rem = (p < MAXP) ? p : MAXP; off = 0; used = 0; bad = 0;
      for (int j = 0; j < NDESC; j++) begin
         d = (start + j) % NDESC;
         ba = BUFB + BSTR * d;
         cp = (dlen(d, start, len, zl) < rem) ? dlen(d, start, len, zl) : rem;
         rem -= cp;
         for (int b = 0; b < cp; b++) if (byte_at(ba + b) !== pb(seed, off + b)) bad++;
         if (byte_at(ba + cp) !== 8'hEE) bad++;
         off += cp; used = j + 1;
         if (rem == 0) begin exp = 32'(cp + 4); tag = (p > MAXP) ? "R10 truncated final status" : "R8 final status"; end
         else if (j + 1 < k) begin exp = CONT | 32'(cp); tag = zl ? "R13 zero-length chain" : "R6 continue status"; end
         else begin exp = 32'(cp); tag = "R7 unowned-next status"; end
         check(mem[(RING >> 2) + 2*d] == exp, tag, mem[(RING >> 2) + 2*d], exp);
         if (rem == 0 || j + 1 >= k) break;
      end
      check(bad == 0, "R1/R4 buffer bytes and guard", bad, 0);
      untouched = 0;
      for (int j = used; j < NDESC; j++) begin
         d = (start + j) % NDESC;
         if (mem[(RING >> 2) + 2*d] != (((j < k) ? OWN : 32'h0) | ((d == NDESC - 1) ? WRAP : 32'h0)
                                        | 32'(dlen(d, start, len, zl)))) untouched++;
      end
      check(untouched == 0, "R5 unused descriptors untouched", untouched, 0);
      reg_read(4'h8, rd);
      exp = RING + 8 * ((start + used) % NDESC);
      check(rd == exp, "R5 pointer after last used", rd, exp);
      check(irq_cnt == 1, "R9 one interrupt", irq_cnt, 1);
      check(irq_last_wr == first_watch, "R9 first status written last", irq_last_wr, first_watch);
      check(first_wr_cnt == 1, "R9 first status written once", first_wr_cnt, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int lens [5] = '{1, 3, 4, 5, 12};
      int pls [6] = '{1, 4, 5, 9, 13, 45};
      repeat (3) @(negedge clk);
      check(irq == 0 && mem_req == 0, "R11 reset outputs idle", {30'b0, irq, mem_req}, 0);
      reg_read(4'h8, rd); check(rd == 0, "R11 reset pointer", rd, 0);
      rst_n = 1;
      reg_read(4'h4, rd); check(rd == 0, "R11 reset ring start", rd, 0);
      // R2: ring start zero drops the packet
      setup_ring(0, 5, 8, 0);
      reg_write(4'h8, RING);
      wr_cnt = 0; irq_cnt = 0;
      send_pkt(6, 3);
      repeat (40) @(negedge clk);
      check(wr_cnt == 0, "R2 no write with zero ring", wr_cnt, 0);
      check(irq_cnt == 0, "R2 no interrupt with zero ring", irq_cnt, 0);
      reg_read(4'h8, rd); check(rd == RING, "R2 pointer kept", rd, RING);
      // R11 register port
      reg_write(4'h4, RING + 32'h5);
      reg_read(4'h4, rd); check(rd == RING, "R11 ring start low bits forced", rd, RING);
      reg_write(4'hC, 32'h1234);
      reg_read(4'hC, rd); check(rd == 0, "R11 unmapped offset reads zero", rd, 0);
      reg_read(4'h0, rd); check(rd == 0, "R11 offset zero reads zero", rd, 0);
      reg_read(4'h4, rd); check(rd == RING, "R11 unmapped write ignored", rd, RING);
      // sweep: buffer length x packet length, ring position rotating
      for (int li = 0; li < 5; li++)
         for (int pi = 0; pi < 6; pi++)
            run_case(lens[li], pls[pi], (li + pi) % NDESC, 5, 0, li * 6 + pi);
      run_case(4, 20, 4, 3, 0, 77);   // R7 chain stops at unowned descriptor
      run_case(4, 9, 5, 5, 1, 91);    // R13 zero-length buffer in the chain
      run_case(4, 9, 2, 0, 0, 12);    // R3 first descriptor not owned
      run_case(12, 40, 3, 5, 0, 55);  // R10 limit exactly on packet end
      check(wide_cnt == 0, "R9 interrupt width one cycle", wide_cnt, 0);
      check(mis_cnt == 0, "R12 aligned requests", mis_cnt, 0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule